// File: doc/BRIEF.md
# Saturating Q15 Vector Multiply-Add Unit

This block is a SIMD arithmetic datapath for fixed-point signal processing. It takes three 128-bit operand vectors, A, B and C, and treats each one as eight signed 16-bit lanes. Every lane works alone and in parallel with the others. The unit multiplies the A and B lanes as Q15 fractions and keeps the upper part of the product. It then adds the C lane and clamps the sum to the signed 16-bit range. The usual use is a filter tap: the coefficient is multiplied by the sample and the product is accumulated onto a running value.

A one-bit mode input chooses between two forms. The rounding form adds half an LSB (0x4000) to the full product before the arithmetic shift right by 15. The truncating form shifts without that bias. The two forms differ in nothing else.

A sticky status bit records that some lane has clamped since the last clear. A synchronous clear input resets it. Operands are accepted when `in_valid` is high. The result and `out_valid` appear one clock later.

Top module: `vq_madd`

## Requirements
- R1: Lane i of every vector occupies bits [127-16*i : 112-16*i], so lane 0 is the most-significant half-word. Each lane's result depends only on the same lane of A, B and C.
- R2: With `mode` = 1 (rounding), each lane computes p = (A*B + 0x4000) >>> 15 on the signed 32-bit product.
- R3: With `mode` = 0 (truncating), each lane computes p = (A*B) >>> 15 with no bias.
- R4: Each lane's result is p + C, formed without wrap, and clamped to the range -32768..+32767.
- R5: A lane whose unclamped sum lies outside -32768..+32767 on an accepted operation sets `sat_flag`. This includes the case where only the rounding bias pushes the sum out of range. No other event sets the flag.
- R6: When A = B = -32768, the shifted product is +32768 in both modes. With C >= 0 the lane gives +32767 and saturates. With a negative C the lane gives 32768 + C and does not saturate.
- R7: `result` and `out_valid` update exactly one clock after `in_valid` is high. While `in_valid` is low, `out_valid` falls on the next edge and `result` keeps its value.
- R8: `sat_clr` clears `sat_flag` on the next edge. If an accepted operation saturates in the same cycle, the flag is set instead.
- R9: When `rst_n` is low, `result`, `out_valid` and `sat_flag` are all zero.
- R10: Once set, `sat_flag` stays set through operations that do not saturate, until it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands are valid and accepted this cycle |
| mode | input | 1 | 1 = rounding form, 0 = truncating form |
| op_a | input | 128 | Multiplicand vector, eight signed lanes |
| op_b | input | 128 | Multiplier vector, eight signed lanes |
| op_c | input | 128 | Addend vector, eight signed lanes |
| sat_clr | input | 1 | Synchronous clear of the sticky saturation bit |
| out_valid | output | 1 | Result register holds a new result |
| result | output | 128 | Clamped lane results, lane 0 in the top bits |
| sat_flag | output | 1 | Sticky saturation status |

## Verification
Every product, sum and clamp is due on the first rising edge after the cycle in which `in_valid` was high. The `out_valid` level and the sticky bit, including a clear, settle on that same edge. The bench drives the operands on a falling edge and advances its behavioural model on the next rising edge. It compares all three outputs on the falling edge that follows, so each comparison looks at exactly one register stage. Idle cycles are compared the same way, which confirms that the result holds and that the flag neither rises nor falls without cause.

// File: rtl/vq_pkg.sv
package vq_pkg;

   typedef enum logic {
      VQ_TRUNC = 1'b0,
      VQ_ROUND = 1'b1
   } vq_mode_e;

   // largest positive value of a signed field of width w
   function automatic longint vq_smax(input int w);
      return (longint'(1) << (w - 1)) - 1;
   endfunction

   // most negative value of a signed field of width w
   function automatic longint vq_smin(input int w);
      return -(longint'(1) << (w - 1));
   endfunction

   function automatic int vq_max2(input int x, input int y);
      return (x > y) ? x : y;
   endfunction

endpackage

// File: rtl/vq_lane_mul.sv
module vq_lane_mul #(
   parameter int LANE_W = 16,
   parameter int FRAC_W = 15,
   localparam int PROD_W = 2 * LANE_W,
   localparam int HI_W   = PROD_W - FRAC_W
) (
   input  logic signed [LANE_W-1:0] a_i,
   input  logic signed [LANE_W-1:0] b_i,
   input  logic                     rnd_i,
   output logic signed [HI_W-1:0]   hi_o
);

   if (FRAC_W < 1 || FRAC_W >= LANE_W) begin : g_bad_frac
      $error("vq_lane_mul: FRAC_W must lie in 1..LANE_W-1");
   end

   localparam logic signed [PROD_W-1:0] BIAS = PROD_W'(1) << (FRAC_W - 1);

   logic signed [PROD_W-1:0] prod;
   logic signed [PROD_W-1:0] bias_v;
   logic signed [PROD_W-1:0] biased;
   logic                     unused_lsbs;

   // full-width signed product; the extreme magnitude plus bias still fits
   assign prod   = a_i * b_i;
   assign bias_v = rnd_i ? BIAS : '0;
   assign biased = prod + bias_v;

   // arithmetic shift right by FRAC_W == upper bits of the signed word
   assign hi_o        = biased[PROD_W-1:FRAC_W];
   assign unused_lsbs = ^biased[FRAC_W-1:0];

endmodule

// File: rtl/vq_lane_sat.sv
module vq_lane_sat
   import vq_pkg::*;
#(
   parameter int IN_W   = 17,
   parameter int LANE_W = 16,
   localparam int SUM_W = vq_max2(IN_W, LANE_W) + 1
) (
   input  logic signed [IN_W-1:0]   hi_i,
   input  logic signed [LANE_W-1:0] c_i,
   output logic        [LANE_W-1:0] res_o,
   output logic                     ovf_o
);

   if (IN_W < LANE_W) begin : g_bad_width
      $error("vq_lane_sat: IN_W narrower than a lane");
   end

   localparam logic signed [SUM_W-1:0] MAXV = SUM_W'(vq_smax(LANE_W));
   localparam logic signed [SUM_W-1:0] MINV = SUM_W'(vq_smin(LANE_W));
   localparam logic [LANE_W-1:0] MAX_CODE = {1'b0, {(LANE_W-1){1'b1}}};
   localparam logic [LANE_W-1:0] MIN_CODE = {1'b1, {(LANE_W-1){1'b0}}};

   logic signed [SUM_W-1:0] hi_ext;
   logic signed [SUM_W-1:0] c_ext;
   logic signed [SUM_W-1:0] sum;
   logic                    above;
   logic                    below;

   assign hi_ext = $signed({{(SUM_W-IN_W){hi_i[IN_W-1]}}, hi_i});
   assign c_ext  = $signed({{(SUM_W-LANE_W){c_i[LANE_W-1]}}, c_i});
   assign sum    = hi_ext + c_ext;

   assign above = (sum > MAXV);
   assign below = (sum < MINV);
   assign ovf_o = above | below;

   always_comb begin
      if (above)      res_o = MAX_CODE;
      else if (below) res_o = MIN_CODE;
      else            res_o = sum[LANE_W-1:0];
   end

endmodule

// File: rtl/vq_sticky.sv
module vq_sticky (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);

   // a set in the same cycle as a clear takes priority
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag_o <= 1'b0;
      else if (set_i) flag_o <= 1'b1;
      else if (clr_i) flag_o <= 1'b0;
   end

endmodule

// File: rtl/vq_madd.sv
module vq_madd
   import vq_pkg::*;
#(
   parameter int LANES     = 8,
   parameter int LANE_W    = 16,
   parameter int FRAC_W    = 15,
   parameter bit LANE0_MSB = 1'b1,
   localparam int VEC_W  = LANES * LANE_W,
   localparam int HI_W   = 2 * LANE_W - FRAC_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             mode,
   input  logic [VEC_W-1:0] op_a,
   input  logic [VEC_W-1:0] op_b,
   input  logic [VEC_W-1:0] op_c,
   input  logic             sat_clr,
   output logic             out_valid,
   output logic [VEC_W-1:0] result,
   output logic             sat_flag
);

   if (LANES < 1) begin : g_bad_lanes
      $error("vq_madd: LANES must be at least 1");
   end
   if (LANE_W < 2) begin : g_bad_lane_w
      $error("vq_madd: LANE_W must be at least 2");
   end

   vq_mode_e         mode_e;
   logic             rnd;
   logic [VEC_W-1:0] lane_res;
   logic [LANES-1:0] lane_ovf;
   logic             any_ovf;

   assign mode_e = vq_mode_e'(mode);
   assign rnd    = (mode_e == VQ_ROUND);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      // LANE0_MSB picks which end of the vector lane 0 sits at
      localparam int LO = LANE0_MSB ? (VEC_W - (i + 1) * LANE_W) : (i * LANE_W);

      logic signed [HI_W-1:0] hi;

      vq_lane_mul #(
         .LANE_W (LANE_W),
         .FRAC_W (FRAC_W)
      ) u_mul (
         .a_i   ($signed(op_a[LO +: LANE_W])),
         .b_i   ($signed(op_b[LO +: LANE_W])),
         .rnd_i (rnd),
         .hi_o  (hi)
      );

      vq_lane_sat #(
         .IN_W   (HI_W),
         .LANE_W (LANE_W)
      ) u_sat (
         .hi_i  (hi),
         .c_i   ($signed(op_c[LO +: LANE_W])),
         .res_o (lane_res[LO +: LANE_W]),
         .ovf_o (lane_ovf[i])
      );
   end

   assign any_ovf = |lane_ovf;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) result <= lane_res;
      end
   end

   vq_sticky u_sticky (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (in_valid & any_ovf),
      .clr_i  (sat_clr),
      .flag_o (sat_flag)
   );

endmodule

// File: rtl/vq_madd_chk.sv
module vq_madd_chk #(
   parameter int VEC_W  = 128,
   parameter int LANE_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [VEC_W-1:0] op_a,
   input logic [VEC_W-1:0] op_b,
   input logic [VEC_W-1:0] op_c,
   input logic             sat_clr,
   input logic             out_valid,
   input logic [VEC_W-1:0] result,
   input logic             sat_flag
);

   localparam logic [LANE_W-1:0] MOST_NEG = {1'b1, {(LANE_W-1){1'b0}}};
   localparam logic [LANE_W-1:0] MOST_POS = {1'b0, {(LANE_W-1){1'b1}}};

   logic min_sq_pos_c;
   assign min_sq_pos_c = (op_a[VEC_W-1 -: LANE_W] == MOST_NEG) &&
                         (op_b[VEC_W-1 -: LANE_W] == MOST_NEG) &&
                         !op_c[VEC_W-1];

   AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R7
   AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid); // R7
   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(result)); // R7
   AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      sat_flag && !sat_clr |=> sat_flag); // R10
   AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      sat_clr && !in_valid |=> !sat_flag); // R8
   AST_SET_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid && !sat_flag |=> !sat_flag); // R5
   AST_MIN_SQUARED: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && min_sq_pos_c |=> sat_flag && (result[VEC_W-1 -: LANE_W] == MOST_POS)); // R6

endmodule

bind vq_madd vq_madd_chk #(.VEC_W(VEC_W), .LANE_W(LANE_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .op_a      (op_a),
   .op_b      (op_b),
   .op_c      (op_c),
   .sat_clr   (sat_clr),
   .out_valid (out_valid),
   .result    (result),
   .sat_flag  (sat_flag)
);

// File: tb/vq_madd_tb.sv
`timescale 1ns/1ps
module vq_madd_tb_top;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic         mode = 1'b0;
   logic [127:0] op_a = '0;
   logic [127:0] op_b = '0;
   logic [127:0] op_c = '0;
   logic         sat_clr = 1'b0;
   logic         out_valid;
   logic [127:0] result;
   logic         sat_flag;

   int n_checks = 0;
   int n_errors = 0;

   logic [127:0] exp_res = '0;
   logic         exp_vld = 1'b0;
   logic         exp_sat = 1'b0;

   always #2.5 clk = ~clk;

   vq_madd dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .mode      (mode),
      .op_a      (op_a),
      .op_b      (op_b),
      .op_c      (op_c),
      .sat_clr   (sat_clr),
      .out_valid (out_valid),
      .result    (result),
      .sat_flag  (sat_flag)
   );

   // behavioural lane reference in plain integers
   function automatic void ref_lane(input logic [15:0] a, input logic [15:0] b,
                                    input logic [15:0] c, input logic m,
                                    output logic [15:0] r, output bit ovf);
      int p;
      int s;
      p = $signed(a) * $signed(b);
      if (m) p = p + 16384;
      p = p >>> 15;
      s = p + int'($signed(c));
      ovf = (s > 32767) || (s < -32768);
      if (s > 32767)       r = 16'h7FFF;
      else if (s < -32768) r = 16'h8000;
      else                 r = s[15:0];
   endfunction

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [127:0] got, input logic [127:0] exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s got %h exp %h", tag, what, got, exp);
      end
   endtask

   // at a falling edge: drive, take the rising edge, update model, compare
   task automatic step(input logic v, input logic m, input logic [127:0] a,
                       input logic [127:0] b, input logic [127:0] c,
                       input logic clr, input string tag);
      logic [127:0] nres;
      bit any;
      in_valid = v; mode = m; op_a = a; op_b = b; op_c = c; sat_clr = clr;
      any = 1'b0;
      nres = '0;
      for (int i = 0; i < 8; i++) begin
         logic [15:0] r;
         bit o;
         ref_lane(a[127-16*i -: 16], b[127-16*i -: 16], c[127-16*i -: 16], m, r, o);
         nres[127-16*i -: 16] = r;
         any |= o;
      end
      @(posedge clk);
      exp_vld = v;
      if (v) exp_res = nres;
      if (v && any)  exp_sat = 1'b1;
      else if (clr)  exp_sat = 1'b0;
      @(negedge clk);
      check(result === exp_res, tag, "result", result, exp_res);
      check(out_valid === exp_vld, tag, "out_valid", 128'(out_valid), 128'(exp_vld));
      check(sat_flag === exp_sat, tag, "sat_flag", 128'(sat_flag), 128'(exp_sat));
   endtask

   function automatic logic [127:0] splat(input logic [15:0] x);
      return {8{x}};
   endfunction

   initial begin
      #(5.0 * 150000);
      n_errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R9: reset state
      check(result === '0, "R9", "result", result, '0);
      check(out_valid === 1'b0, "R9", "out_valid", 128'(out_valid), 0);
      check(sat_flag === 1'b0, "R9", "sat_flag", 128'(sat_flag), 0);
      rst_n = 1'b1;
      step(0, 0, '0, '0, '0, 0, "R9");

      // R1/R2: distinct lanes times 0.5, rounding
      step(1, 1, 128'h0001_0003_0005_7FFF_8000_FFFF_1234_4321, splat(16'h4000),
           128'h0000_0001_0002_0003_0004_0005_0006_0007, 0, "R1");
      step(1, 1, 128'h0100_FF00_2000_E000_0003_FFFD_7FFF_8001,
           128'h0080_0080_3000_3000_4000_4000_7FFF_7FFF, '0, 0, "R2");
      // R3: the same operands truncated
      step(1, 0, 128'h0100_FF00_2000_E000_0003_FFFD_7FFF_8001,
           128'h0080_0080_3000_3000_4000_4000_7FFF_7FFF, '0, 0, "R3");
      // R4: clamp high and low in lanes 0 and 7 only
      step(1, 0, 128'h4000_0000_0000_0000_0000_0000_0000_C000, splat(16'h7FFF),
           128'h7000_0000_0000_0000_0000_0000_0000_9000, 0, "R4");
      step(0, 0, '0, '0, '0, 1, "R8");
      // R5: truncating stays at +32767, rounding bias alone saturates
      step(1, 0, splat(16'h0080), splat(16'h0080), splat(16'h7FFF), 0, "R5");
      step(1, 1, splat(16'h0080), splat(16'h0080), splat(16'h7FFF), 0, "R5");
      // R10: a clean result does not clear the sticky bit
      step(1, 1, splat(16'h0100), splat(16'h0100), '0, 0, "R10");
      step(0, 1, '0, '0, '0, 0, "R10");
      // R8: clear while idle, then clear and saturate together
      step(0, 0, '0, '0, '0, 1, "R8");
      step(1, 1, splat(16'h8000), splat(16'h8000), '0, 1, "R8");
      step(0, 0, '0, '0, '0, 1, "R8");
      // R6: most negative squared, zero / negative addends, both modes
      step(1, 0, splat(16'h8000), splat(16'h8000), '0, 0, "R6");
      step(0, 0, '0, '0, '0, 1, "R6");
      step(1, 1, splat(16'h8000), splat(16'h8000), splat(16'hFFFB), 0, "R6");
      step(1, 0, splat(16'h8000), splat(16'h8000), splat(16'hFFFF), 0, "R6");
      // R7: result holds over idle cycles
      step(0, 1, splat(16'h1111), splat(16'h2222), splat(16'h3333), 0, "R7");
      step(0, 0, splat(16'h7FFF), splat(16'h7FFF), splat(16'h7FFF), 0, "R7");

      // mixed patterns, compared on every cycle against the model
      for (int k = 0; k < 400; k++) begin
         logic [127:0] a, b, c;
         a = {$urandom, $urandom, $urandom, $urandom};
         b = {$urandom, $urandom, $urandom, $urandom};
         c = {$urandom, $urandom, $urandom, $urandom};
         if (k % 7 == 0) a[127:112] = 16'h8000;
         if (k % 5 == 0) b[127:112] = 16'h8000;
         step(($urandom % 4) != 0, $urandom % 2, a, b, c, ($urandom % 6) == 0, "R4");
      end

      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule